// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block updates the privileged architectural state of a processor core when a trap is taken. A trap arrives as a cause word, the program counter of the faulting instruction and an optional faulting address. The unit decides whether the trap is handled in supervisor or in machine mode. Interrupt causes have their top bit set and are looked up in the interrupt delegation mask. All other causes are looked up in the exception delegation mask. On the same clock edge it writes the cause, return-PC and faulting-address registers of the chosen mode, loads the next PC, stacks the interrupt-enable and previous-privilege fields, and raises the privilege.

The trap input is a valid/ready stream of one word per trap. Ready is high in every cycle outside reset, so a trap is accepted in the cycle its valid is seen and the source never stalls. Valid must not depend on ready. A separate plain restore port lets trap-return logic elsewhere load the privilege and the enable bits. Every privilege change gives a one-cycle address-translation flush pulse, and every trap gives a one-cycle pulse that drops any load reservation.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege is M (code 3), the PC is the machine vector base plus 0x100, all enable and stacked status bits are 0, all cause/return-PC/faulting-address registers are 0, and both pulses are low.
- R2: If the top bit of the cause is 1, the interrupt delegation mask is indexed by the cause with that bit cleared. Otherwise the exception delegation mask is indexed by the cause.
- R3: A trap goes to supervisor mode only when the current privilege is U (0) or S (1), the index is below XLEN, and the selected mask bit is 1. Every other trap goes to machine mode.
- R4: On a supervisor trap the PC becomes the supervisor vector input with its two low bits cleared. The supervisor cause register gets the full cause and the supervisor return-PC gets the trap PC. The machine registers are left unchanged.
- R5: A faulting-address register of the chosen mode is written only when the trap's address-valid bit is 1. Otherwise both faulting-address registers keep their values.
- R6: On a supervisor trap, the supervisor previous-enable gets the enable bit at the position of the current privilege code. The supervisor previous-privilege gets bit 0 of the current privilege. Enable bit 1 (supervisor) is cleared and the privilege becomes S.
- R7: On a machine trap the PC becomes the machine vector base plus 0x40 times the current privilege code. The machine cause, return-PC and faulting-address registers are written as in R4 and R5, and the supervisor registers are left unchanged.
- R8: On a machine trap, the machine previous-enable gets the enable bit at the position of the current privilege code. The machine previous-privilege gets the current privilege. Enable bit 3 (machine) is cleared and the privilege becomes M.
- R9: The flush output is high for exactly one cycle after every accepted trap and every accepted privilege restore. The reservation-drop output is high for exactly one cycle after every accepted trap.
- R10: A privilege restore with the reserved code 2 is ignored: the privilege is unchanged and there is no flush pulse.
- R11: Ready is low during reset and high otherwise. When a trap and restore writes arrive in the same cycle, the trap takes effect and the restore writes are dropped.
- R12: The enable vector holds user, supervisor and machine enables at bits 0, 1 and 3. Bit 2 always reads 0, even when a restore writes 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_valid | input | 1 | Trap word valid |
| trap_ready | output | 1 | Unit can accept a trap |
| trap_cause | input | XLEN | Cause; top bit marks an interrupt |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_badaddr | input | XLEN | Faulting address |
| trap_badaddr_valid | input | 1 | Faulting address accompanies the trap |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| s_vector | input | XLEN | Supervisor trap vector |
| rst_priv_en | input | 1 | Restore the privilege |
| rst_priv_val | input | 2 | Privilege to restore |
| rst_ie_en | input | 1 | Restore the enable vector |
| rst_ie_val | input | 4 | Enable vector to restore |
| priv | output | 2 | Current privilege (U=0, S=1, M=3) |
| pc | output | XLEN | Next PC |
| s_cause | output | XLEN | Supervisor cause |
| s_epc | output | XLEN | Supervisor return PC |
| s_badaddr | output | XLEN | Supervisor faulting address |
| m_cause | output | XLEN | Machine cause |
| m_epc | output | XLEN | Machine return PC |
| m_badaddr | output | XLEN | Machine faulting address |
| ie | output | 4 | Enable vector (bits 0, 1, 3) |
| s_pie | output | 1 | Supervisor previous-enable |
| s_pp | output | 1 | Supervisor previous-privilege |
| m_pie | output | 1 | Machine previous-enable |
| m_pp | output | 2 | Machine previous-privilege |
| tlb_flush | output | 1 | Translation flush pulse |
| resv_clear | output | 1 | Load reservation drop pulse |

## Verification
The routing is tried from each starting privilege with exception and interrupt causes. In some of these patterns only the opposite mask has the bit set, which separates correct mask selection from a merged mask. A cause index of XLEN or more, paired with an all-ones mask, shows that the range check rather than a truncated index decides the route. Different enable patterns per starting privilege show that the stacked previous-enable reads the bit at the privilege's own position. Alternating the address-valid bit shows the faulting-address registers holding their value.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int IE_W = 4;
  localparam logic [IE_W-1:0] IE_MASK = 4'b1011;
  localparam int MODE_S = 0;
  localparam int MODE_M = 1;
  localparam int N_MODES = 2;

  function automatic logic priv_ok(input logic [1:0] p);
    return p != PRIV_RSV;
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] irq_deleg_i,
  input  priv_e           cur_priv_i,
  output logic            to_s_o
);
  localparam int IDXW = $clog2(XLEN);

  logic            is_irq;
  logic [XLEN-1:0] code;
  logic [XLEN-1:0] mask;
  logic            in_range;

  always_comb begin
    is_irq   = cause_i[XLEN-1];
    code     = {1'b0, cause_i[XLEN-2:0]};
    mask     = is_irq ? irq_deleg_i : exc_deleg_i;
    in_range = code < XLEN'(XLEN);
    to_s_o   = (cur_priv_i <= PRIV_S) && in_range && mask[code[IDXW-1:0]];
  end

  // R3: supervisor routing never taken from machine level
  always_comb begin
    if (to_s_o) p_route_level_r3: assert (cur_priv_i != PRIV_M);
  end
endmodule

// File: rtl/trap_mode_regs.sv
module trap_mode_regs #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] bad_i,
  input  logic            bad_vld_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] bad_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o <= '0;
      epc_o   <= '0;
      bad_o   <= '0;
    end else if (wr_i) begin
      cause_o <= cause_i;
      epc_o   <= epc_i;
      if (bad_vld_i) bad_o <= bad_i;
    end
  end

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_i && bad_vld_i) |-> $stable(bad_o));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] MVEC_BASE = 'h1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_valid,
  output logic            trap_ready,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [XLEN-1:0] trap_badaddr,
  input  logic            trap_badaddr_valid,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [XLEN-1:0] irq_deleg,
  input  logic [XLEN-1:0] s_vector,
  input  logic            rst_priv_en,
  input  logic [1:0]      rst_priv_val,
  input  logic            rst_ie_en,
  input  logic [3:0]      rst_ie_val,
  output logic [1:0]      priv,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_badaddr,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_badaddr,
  output logic [3:0]      ie,
  output logic            s_pie,
  output logic            s_pp,
  output logic            m_pie,
  output logic [1:0]      m_pp,
  output logic            tlb_flush,
  output logic            resv_clear
);
  localparam logic [XLEN-1:0] RESET_PC = MVEC_BASE + XLEN'(256);

  priv_e           priv_q;
  logic [IE_W-1:0] ie_q;
  logic            fire;
  logic            to_s;
  logic            cur_ie;
  logic            restore_ok;
  logic [XLEN-1:0] bank_cause [N_MODES];
  logic [XLEN-1:0] bank_epc   [N_MODES];
  logic [XLEN-1:0] bank_bad   [N_MODES];

  assign trap_ready = !rst;
  assign fire       = trap_valid && trap_ready;
  assign cur_ie     = ie_q[priv_q];
  assign restore_ok = rst_priv_en && priv_ok(rst_priv_val);

  trap_route #(.XLEN(XLEN)) u_route (
    .cause_i     (trap_cause),
    .exc_deleg_i (exc_deleg),
    .irq_deleg_i (irq_deleg),
    .cur_priv_i  (priv_q),
    .to_s_o      (to_s)
  );

  for (genvar g = 0; g < N_MODES; g++) begin : g_bank
    trap_mode_regs #(.XLEN(XLEN)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_i      (fire && (to_s == (g == MODE_S))),
      .cause_i   (trap_cause),
      .epc_i     (trap_epc),
      .bad_i     (trap_badaddr),
      .bad_vld_i (trap_badaddr_valid),
      .cause_o   (bank_cause[g]),
      .epc_o     (bank_epc[g]),
      .bad_o     (bank_bad[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q     <= PRIV_M;
      pc         <= RESET_PC;
      ie_q       <= '0;
      s_pie      <= 1'b0;
      s_pp       <= 1'b0;
      m_pie      <= 1'b0;
      m_pp       <= 2'd0;
      tlb_flush  <= 1'b0;
      resv_clear <= 1'b0;
    end else begin
      tlb_flush  <= 1'b0;
      resv_clear <= 1'b0;
      if (fire) begin
        tlb_flush  <= 1'b1;
        resv_clear <= 1'b1;
        if (to_s) begin
          pc       <= {s_vector[XLEN-1:2], 2'b00};
          s_pie    <= cur_ie;
          s_pp     <= priv_q[0];
          ie_q[1]  <= 1'b0;
          priv_q   <= PRIV_S;
        end else begin
          pc       <= MVEC_BASE + XLEN'({priv_q, 6'b0});
          m_pie    <= cur_ie;
          m_pp     <= priv_q;
          ie_q[3]  <= 1'b0;
          priv_q   <= PRIV_M;
        end
      end else begin
        if (restore_ok) begin
          priv_q    <= priv_e'(rst_priv_val);
          tlb_flush <= 1'b1;
        end
        if (rst_ie_en) ie_q <= rst_ie_val & IE_MASK;
      end
    end
  end

  assign priv      = priv_q;
  assign ie        = ie_q;
  assign s_cause   = bank_cause[MODE_S];
  assign s_epc     = bank_epc[MODE_S];
  assign s_badaddr = bank_bad[MODE_S];
  assign m_cause   = bank_cause[MODE_M];
  assign m_epc     = bank_epc[MODE_M];
  assign m_badaddr = bank_bad[MODE_M];

  p_strap_state_r6: assert property (@(posedge clk) disable iff (rst)
    $past(fire && to_s) |-> (priv_q == PRIV_S && !ie_q[1]));

  p_mtrap_state_r8: assert property (@(posedge clk) disable iff (rst)
    $past(fire && !to_s) |-> (priv_q == PRIV_M && !ie_q[3]));

  p_flush_src_r9: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> $past(fire || restore_ok));

  p_resv_src_r9: assert property (@(posedge clk) disable iff (rst)
    resv_clear |-> $past(fire));

  p_priv_legal_r10: assert property (@(posedge clk) disable iff (rst)
    priv_q != PRIV_RSV);

  p_ie_rsv_r12: assert property (@(posedge clk) disable iff (rst)
    !ie_q[2]);

  p_restore_drop_r11: assert property (@(posedge clk) disable iff (rst)
    $past(fire) |-> priv_q != PRIV_U);
endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam logic [XLEN-1:0] BASE = 64'h1000;
  localparam logic [XLEN-1:0] SVEC = 64'h2003;
  localparam int NV = 8;
  localparam int V_PRV  [NV] = '{0, 1, 3, 0, 0, 1,  0, 1};
  localparam int V_IE   [NV] = '{1, 2, 8, 0, 1, 10, 0, 0};
  localparam int V_INTR [NV] = '{0, 0, 0, 1, 1, 0,  0, 1};
  localparam int V_IDX  [NV] = '{2, 5, 3, 1, 7, 8, 70, 9};
  localparam int V_ED   [NV] = '{1, 0, 1, 0, 1, 1,  2, 0};
  localparam int V_ID   [NV] = '{0, 0, 0, 1, 0, 0,  0, 1};

  logic clk = 0, rst = 1;
  logic trap_valid = 0, trap_ready;
  logic [XLEN-1:0] trap_cause = '0, trap_epc = '0, trap_badaddr = '0;
  logic trap_badaddr_valid = 0;
  logic [XLEN-1:0] exc_deleg = '0, irq_deleg = '0, s_vector = SVEC;
  logic rst_priv_en = 0, rst_ie_en = 0;
  logic [1:0] rst_priv_val = 0;
  logic [3:0] rst_ie_val = 0;
  logic [1:0] priv, m_pp;
  logic [XLEN-1:0] pc, s_cause, s_epc, s_badaddr, m_cause, m_epc, m_badaddr;
  logic [3:0] ie;
  logic s_pie, s_pp, m_pie, tlb_flush, resv_clear;

  int checks = 0, errors = 0;
  logic [XLEN-1:0] e_sc = 0, e_se = 0, e_sb = 0, e_mc = 0, e_me = 0, e_mb = 0;
  logic e_spie = 0, e_spp = 0, e_mpie = 0;
  logic [1:0] e_mpp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .MVEC_BASE(BASE)) uut (.*);

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic restore(input logic [1:0] p, input logic [3:0] v);
    rst_priv_en = 1; rst_priv_val = p; rst_ie_en = 1; rst_ie_val = v;
    @(negedge clk);
    rst_priv_en = 0; rst_ie_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk("R11 ready low in reset", {63'd0, trap_ready}, 0);
    @(negedge clk); rst = 0; @(negedge clk);
    chk("R1 priv", {62'd0, priv}, 3);
    chk("R1 pc", pc, BASE + 64'h100);
    chk("R1 ie", {60'd0, ie}, 0);
    chk("R1 causes", s_cause | m_cause | s_epc | m_epc, 0);
    chk("R1 pulses", {62'd0, tlb_flush, resv_clear}, 0);
    chk("R11 ready", {63'd0, trap_ready}, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] p;
      logic [3:0] ie0;
      logic [XLEN-1:0] c, ed, id, code, ep, ba;
      logic bv, exp_s, mbit;
      p = 2'(V_PRV[i]); ie0 = 4'(V_IE[i]);
      restore(p, ie0);
      code = 64'(V_IDX[i]);
      c  = V_INTR[i] != 0 ? (64'd1 << 63) | code : code;
      ed = V_ED[i] == 2 ? '1 : (V_ED[i] == 1 ? 64'd1 << code : 64'd0);
      id = V_ID[i] == 1 ? 64'd1 << code : 64'd0;
      ep = 64'h8000_0000 + 64'(i * 4);
      ba = 64'hBAD0 + 64'(i);
      bv = (i % 2) == 0;
      mbit = V_INTR[i] != 0 ? id[code[5:0]] : ed[code[5:0]];
      exp_s = (p <= 1) && (code < 64) && mbit;
      exc_deleg = ed; irq_deleg = id;
      trap_cause = c; trap_epc = ep; trap_badaddr = ba; trap_badaddr_valid = bv;
      trap_valid = 1;
      @(negedge clk);
      trap_valid = 0;
      if (exp_s) begin
        e_sc = c; e_se = ep; if (bv) e_sb = ba;
        e_spie = ie0[p]; e_spp = p[0];
        chk("R2/R3 target S", {62'd0, priv}, 1);
        chk("R4 pc", pc, {SVEC[63:2], 2'b00});
        chk("R6 ie", {60'd0, ie}, {60'd0, ie0 & 4'b1101});
      end else begin
        e_mc = c; e_me = ep; if (bv) e_mb = ba;
        e_mpie = ie0[p]; e_mpp = p;
        chk("R2/R3 target M", {62'd0, priv}, 3);
        chk("R7 pc", pc, BASE + 64'(p) * 64'h40);
        chk("R8 ie", {60'd0, ie}, {60'd0, ie0 & 4'b0111});
      end
      chk("R4 s_cause", s_cause, e_sc);
      chk("R4 s_epc", s_epc, e_se);
      chk("R5 s_badaddr", s_badaddr, e_sb);
      chk("R7 m_cause", m_cause, e_mc);
      chk("R7 m_epc", m_epc, e_me);
      chk("R5 m_badaddr", m_badaddr, e_mb);
      chk("R6 s_pie", {63'd0, s_pie}, {63'd0, e_spie});
      chk("R6 s_pp", {63'd0, s_pp}, {63'd0, e_spp});
      chk("R8 m_pie", {63'd0, m_pie}, {63'd0, e_mpie});
      chk("R8 m_pp", {62'd0, m_pp}, {62'd0, e_mpp});
      chk("R9 pulses high", {62'd0, tlb_flush, resv_clear}, 3);
      @(negedge clk);
      chk("R9 pulses one cycle", {62'd0, tlb_flush, resv_clear}, 0);
    end

    // R10: reserved privilege code ignored
    restore(2'd1, 4'd0);
    @(negedge clk);
    rst_priv_en = 1; rst_priv_val = 2'd2;
    @(negedge clk);
    rst_priv_en = 0;
    chk("R10 priv kept", {62'd0, priv}, 1);
    chk("R10 no flush", {63'd0, tlb_flush}, 0);

    // R12: bit 2 of the enable vector stays 0
    restore(2'd0, 4'hF);
    chk("R12 ie bit2", {60'd0, ie}, 64'hB);

    // R11: trap and restore in the same cycle, trap wins
    exc_deleg = '0; irq_deleg = '0;
    trap_cause = 64'd4; trap_epc = 64'h44; trap_badaddr_valid = 0;
    trap_valid = 1; rst_priv_en = 1; rst_priv_val = 2'd1; rst_ie_en = 1; rst_ie_val = 4'h0;
    @(negedge clk);
    trap_valid = 0; rst_priv_en = 0; rst_ie_en = 0;
    chk("R11 trap wins priv", {62'd0, priv}, 3);
    chk("R11 trap wins ie", {60'd0, ie}, 64'h3);
    chk("R11 pc from U", pc, BASE);
    chk("R8 m_pie from U", {63'd0, m_pie}, 1);

    finish_run();
  end
endmodule